// File: doc/BRIEF.md
# Serial Download Packet Checker

This block sits behind a serial byte receiver. It turns a download stream into RAM writes and a verdict. While it waits for a command, every incoming byte is compared against the download command code, and bytes that do not match are dropped. Once the command is accepted, the block counts stream positions starting from 3, the command byte. It captures a 32-bit entry address and a payload length from the header. Each payload byte is written into a small RAM at an address that counts up from zero. A running 8-bit sum is kept over the payload and the trailing checksum byte.

When the checksum byte arrives, the block returns a one-byte acknowledge. The upper nibble of that byte echoes the command. The lower nibble holds the error flags: bit 3 marks a receive error and bit 0 marks a checksum error. A receive error takes precedence over a checksum error. After any acknowledge, the block waits for a command again. On a clean result it also raises a one-cycle branch request that carries the captured entry address. In synchronous serial mode the receiver's error flag plays no part in the verdict.

Top module: `serial_dl_checker`

## Requirements
- R1: The reset state has ack_vld_o, branch_req_o and ram_we_o low, with the block waiting for a command. Asserting reset in the middle of a packet discards that packet, so the next packet is checked from its command byte.
- R2: While waiting for a command, any byte other than CMD_CODE (default 0x10) is ignored. It produces no acknowledge and no RAM write.
- R3: Payload byte k (0-based, at stream position 27+k) is written to RAM address k modulo 2^ADDR_W, with ram_we_o high one cycle after its strobe. Command, header and checksum bytes are never written.
- R4: Stream positions 23 (MSB) and 24 carry the payload count N as 16 bits. The checksum byte is at stream position 27+N, and N = 0 is legal.
- R5: When the 8-bit sum of the payload and checksum bytes is 0x00 and no receive error counts, ack_o is 0x10. ack_vld_o is high for exactly one cycle, starting one cycle after the checksum byte's strobe.
- R6: When no receive error counts and the sum is not 0x00, ack_o is 0x11.
- R7: A receive error flagged with any byte from position 27 to 27+N gives ack_o 0x18, whatever the sum.
- R8: A receive error flagged with the command byte or a header byte (positions 3 to 26) has no effect on the acknowledge.
- R9: While sync_mode_i is high, rx_err_i is ignored, so the acknowledge depends only on the sum (0x10 or 0x11).
- R10: After a 0x10 acknowledge, branch_req_o is high for one cycle, in the cycle after ack_vld_o. branch_addr_o holds positions 19..22 (19 as MSB) and stays stable meanwhile. Error acknowledges give no branch.
- R11: After any acknowledge, the block waits for a command. A command byte strobed in the acknowledge cycle itself starts the next packet.
- R12: Cycles with byte_vld_i low are ignored, so gaps of any length between bytes do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_vld_i | input | 1 | Received byte strobe |
| byte_i | input | 8 | Received byte |
| rx_err_i | input | 1 | Receive error flag for the strobed byte |
| sync_mode_i | input | 1 | High: synchronous serial mode, receive errors ignored |
| ack_vld_o | output | 1 | Acknowledge strobe |
| ack_o | output | 8 | Acknowledge code |
| ram_we_o | output | 1 | Payload RAM write enable |
| ram_addr_o | output | ADDR_W | Payload RAM address |
| ram_wdata_o | output | 8 | Payload RAM write data |
| branch_req_o | output | 1 | One-cycle branch request |
| branch_addr_o | output | 32 | Branch target address |

## Verification
The next packet's command byte can arrive in the same cycle as the previous acknowledge. The branch request then fires while that new packet's header is being captured. To provoke this, the bench sends packets back to back with no idle cycle after the checksum byte. It then judges that every acknowledge and branch address matches its own packet in order, and that the branch address still belongs to the finished packet.

// File: rtl/dl_pkg.sv
package dl_pkg;
  typedef enum logic {ST_CMD, ST_BODY} dl_state_e;

  // stream positions; the block's framing depends on these
  localparam int unsigned POS_CMD       = 3;
  localparam int unsigned POS_ADDR_MSB  = 19;
  localparam int unsigned POS_ADDR_LSB  = 22;
  localparam int unsigned POS_LEN_FIRST = 23;
  localparam int unsigned POS_DATA      = 27;
endpackage

// File: rtl/dl_pos_counter.sv
module dl_pos_counter
  import dl_pkg::*;
#(
  parameter int unsigned POS_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             adv_i,
  output logic [POS_W-1:0] pos_o
);
  logic [POS_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pos_q <= POS_W'(POS_CMD);
    else if (start_i) pos_q <= POS_W'(POS_CMD + 1);
    else if (adv_i)   pos_q <= pos_q + POS_W'(1);
  end

  assign pos_o = pos_q;

  AST_START_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> pos_o == POS_W'(POS_CMD + 1)) else $error("AST_START_POS"); // R11
endmodule

// File: rtl/dl_hdr_capture.sv
module dl_hdr_capture
  import dl_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned POS_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stb_i,
  input  logic [POS_W-1:0] pos_i,
  input  logic [7:0]       byte_i,
  output logic [31:0]      addr_o,
  output logic [LEN_W-1:0] len_o
);
  localparam int unsigned LEN_BYTES = LEN_W / 8;
  localparam int unsigned LEN_LAST  = POS_LEN_FIRST + LEN_BYTES - 1;

  logic [31:0]      addr_q;
  logic [LEN_W-1:0] len_q;
  logic             addr_hit, len_hit;

  assign addr_hit = stb_i && pos_i >= POS_W'(POS_ADDR_MSB) && pos_i <= POS_W'(POS_ADDR_LSB);
  assign len_hit  = stb_i && pos_i >= POS_W'(POS_LEN_FIRST) && pos_i <= POS_W'(LEN_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= '0;
    else if (addr_hit) addr_q <= {addr_q[23:0], byte_i};
  end

  generate
    if (LEN_W == 8) begin : g_len_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      len_q <= '0;
        else if (start_i) len_q <= '0;
        else if (len_hit) len_q <= byte_i;
      end
    end else begin : g_len_multi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      len_q <= '0;
        else if (start_i) len_q <= '0;
        else if (len_hit) len_q <= {len_q[LEN_W-9:0], byte_i};
      end
    end
  endgenerate

  assign addr_o = addr_q;
  assign len_o  = len_q;

  AST_LEN_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_i && !start_i && pos_i > POS_W'(LEN_LAST)) |=> $stable(len_o)) else $error("AST_LEN_FROZEN"); // R4
endmodule

// File: rtl/dl_sum_check.sv
module dl_sum_check (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       acc_i,
  input  logic [7:0] byte_i,
  input  logic       rx_err_i,
  input  logic       ign_err_i,
  output logic       fail_rx_o,
  output logic       fail_sum_o
);
  logic [7:0] sum_q;
  logic       err_q;
  logic       err_now;

  assign err_now = acc_i && rx_err_i && !ign_err_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      err_q <= 1'b0;
    end else if (start_i) begin
      sum_q <= '0;
      err_q <= 1'b0;
    end else if (acc_i) begin
      sum_q <= sum_q + byte_i;
      err_q <= err_q | err_now;
    end
  end

  // verdict including the byte presented this cycle
  assign fail_rx_o  = err_q | err_now;
  assign fail_sum_o = (sum_q + byte_i) != 8'h00;

  AST_SYNC_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && ign_err_i && !start_i) |=> $stable(err_q)) else $error("AST_SYNC_NO_ERR"); // R9
endmodule

// File: rtl/dl_ram_port.sv
module dl_ram_port #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] idx_i,
  input  logic [7:0]        data_i,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      we_o <= we_i;
      if (we_i) begin
        addr_o <= idx_i;
        data_o <= data_i;
      end
    end
  end
endmodule

// File: rtl/serial_dl_checker.sv
module serial_dl_checker
  import dl_pkg::*;
#(
  parameter logic [7:0]  CMD_CODE = 8'h10,
  parameter int unsigned LEN_W    = 16,
  parameter int unsigned ADDR_W   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              rx_err_i,
  input  logic              sync_mode_i,
  output logic              ack_vld_o,
  output logic [7:0]        ack_o,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  output logic              branch_req_o,
  output logic [31:0]       branch_addr_o
);
  localparam int unsigned POS_W = LEN_W + 1;

  dl_state_e        state_q;
  logic [3:0]       cmd_nib_q;
  logic             ok_q;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] chk_pos;
  logic [LEN_W-1:0] len;
  logic [31:0]      hdr_addr;
  logic             cmd_hit, body_stb, in_span, last, pay_we;
  logic             fail_rx, fail_sum;

  assign cmd_hit  = state_q == ST_CMD && byte_vld_i && byte_i == CMD_CODE;
  assign body_stb = state_q == ST_BODY && byte_vld_i;
  assign chk_pos  = POS_W'(POS_DATA) + POS_W'(len);
  assign in_span  = pos >= POS_W'(POS_DATA);
  assign last     = body_stb && pos == chk_pos;
  assign pay_we   = body_stb && in_span && !last;

  dl_pos_counter #(.POS_W(POS_W)) u_pos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(cmd_hit),
    .adv_i  (body_stb),
    .pos_o  (pos)
  );

  dl_hdr_capture #(.LEN_W(LEN_W), .POS_W(POS_W)) u_hdr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(cmd_hit),
    .stb_i  (body_stb),
    .pos_i  (pos),
    .byte_i (byte_i),
    .addr_o (hdr_addr),
    .len_o  (len)
  );

  dl_sum_check u_sum (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (cmd_hit),
    .acc_i     (body_stb && in_span),
    .byte_i    (byte_i),
    .rx_err_i  (rx_err_i),
    .ign_err_i (sync_mode_i),
    .fail_rx_o (fail_rx),
    .fail_sum_o(fail_sum)
  );

  dl_ram_port #(.ADDR_W(ADDR_W)) u_ram (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (pay_we),
    .idx_i (ADDR_W'(pos - POS_W'(POS_DATA))),
    .data_i(byte_i),
    .we_o  (ram_we_o),
    .addr_o(ram_addr_o),
    .data_o(ram_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_CMD;
      cmd_nib_q <= '0;
    end else if (cmd_hit) begin
      state_q   <= ST_BODY;
      cmd_nib_q <= byte_i[7:4];
    end else if (last) begin
      state_q   <= ST_CMD;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_vld_o     <= 1'b0;
      ack_o         <= '0;
      ok_q          <= 1'b0;
      branch_req_o  <= 1'b0;
      branch_addr_o <= '0;
    end else begin
      ack_vld_o    <= last;
      ok_q         <= last && !fail_rx && !fail_sum;
      branch_req_o <= ok_q;
      if (last) begin
        ack_o <= {cmd_nib_q, fail_rx, 2'b00, !fail_rx && fail_sum};
        if (!fail_rx && !fail_sum) branch_addr_o <= hdr_addr;
      end
    end
  end

  AST_ACK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_vld_o |=> !ack_vld_o) else $error("AST_ACK_PULSE"); // R5
  AST_ACK_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_vld_o |-> (ack_o[2:1] == 2'b00 && !(ack_o[3] && ack_o[0]))) else $error("AST_ACK_CODE"); // R7
  AST_BRANCH_AFTER_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_req_o |-> ($past(ack_vld_o) && $past(ack_o[3:0]) == 4'h0)) else $error("AST_BRANCH_AFTER_OK"); // R10
  AST_BRANCH_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_req_o |-> $stable(branch_addr_o)) else $error("AST_BRANCH_ADDR_STABLE"); // R10
  AST_NO_WE_WITH_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_we_o && ack_vld_o)) else $error("AST_NO_WE_WITH_ACK"); // R3
endmodule

// File: tb/serial_dl_checker_tb_top.sv
`timescale 1ns/1ps
module serial_dl_checker_tb_top;
  localparam int ADDR_W = 6;
  localparam int DEPTH  = 64;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              byte_vld = 1'b0;
  logic [7:0]        byte_d = '0;
  logic              rx_err = 1'b0;
  logic              sync_mode = 1'b0;
  logic              ack_vld_o;
  logic [7:0]        ack_o;
  logic              ram_we_o;
  logic [ADDR_W-1:0] ram_addr_o;
  logic [7:0]        ram_wdata_o;
  logic              branch_req_o;
  logic [31:0]       branch_addr_o;

  always #2.5 clk = ~clk;

  serial_dl_checker #(.CMD_CODE(8'h10), .LEN_W(16), .ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .byte_vld_i(byte_vld), .byte_i(byte_d),
    .rx_err_i(rx_err), .sync_mode_i(sync_mode), .ack_vld_o(ack_vld_o), .ack_o(ack_o),
    .ram_we_o(ram_we_o), .ram_addr_o(ram_addr_o), .ram_wdata_o(ram_wdata_o),
    .branch_req_o(branch_req_o), .branch_addr_o(branch_addr_o)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0]  ack_log [256];
  logic [31:0] br_log  [256];
  logic [7:0]  exp_ack [256];
  logic [31:0] exp_br  [256];
  logic [7:0]  mem  [DEPTH];
  logic [7:0]  emem [DEPTH];
  bit          etouch [DEPTH];
  int ack_n = 0, br_n = 0, we_n = 0, timing_err = 0;
  int eack_n = 0, ebr_n = 0, exp_we = 0, ack_seen = 0, br_seen = 0;
  logic prev_ack = 1'b0, prev_ok = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [7:0] code);
    if (code == 8'h18) return "R7";
    if (code == 8'h11) return "R6";
    return "R5";
  endfunction

  function automatic logic [7:0] exp_code(input bit rx, input bit bad);
    if (rx) return 8'h18;
    if (bad) return 8'h11;
    return 8'h10;
  endfunction

  // output monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_ni) begin
      if (ack_vld_o) begin ack_log[ack_n % 256] = ack_o; ack_n++; end
      if (ack_vld_o && prev_ack) timing_err++;
      if (branch_req_o) begin
        br_log[br_n % 256] = branch_addr_o; br_n++;
        if (!prev_ok) timing_err++;
      end
      if (ram_we_o) begin mem[ram_addr_o] = ram_wdata_o; we_n++; end
      prev_ack = ack_vld_o;
      prev_ok  = ack_vld_o && ack_o == 8'h10;
    end else begin
      prev_ack = 1'b0;
      prev_ok  = 1'b0;
    end
  end

  task automatic idle(input int k);
    repeat (k) begin @(negedge clk); byte_vld = 1'b0; rx_err = 1'b0; end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit e, input int gap);
    idle(gap);
    @(negedge clk); byte_vld = 1'b1; byte_d = b; rx_err = e;
  endtask

  function automatic int pick_gap(input int max_gap);
    if (max_gap == 0) return 0;
    return int'($urandom_range(0, max_gap));
  endfunction

  task automatic send_pkt(input int n, input logic [31:0] addr, input bit bad_sum, input int err_pos,
                          input bit sync, input int max_gap, input bit hdr_err, input int cmd_gap);
    logic [7:0] pay [256];
    logic [7:0] s = 8'h00;
    logic [7:0] csum, b;
    bit rx;
    for (int k = 0; k < n; k++) begin pay[k] = 8'($urandom); s = s + pay[k]; end
    csum = 8'h00 - s;
    if (bad_sum) csum = csum ^ 8'h5A;
    send_byte(8'h10, hdr_err, cmd_gap);
    sync_mode = sync;
    for (int p = 4; p <= 26; p++) begin
      if (p >= 19 && p <= 22) b = addr[8*(22-p) +: 8];
      else if (p == 23) b = 8'(n >> 8);
      else if (p == 24) b = 8'(n);
      else b = 8'($urandom);
      send_byte(b, (hdr_err && p == 10) || p == err_pos, pick_gap(max_gap));
    end
    for (int k = 0; k < n; k++) begin
      send_byte(pay[k], (27 + k) == err_pos, pick_gap(max_gap));
      emem[k % DEPTH] = pay[k]; etouch[k % DEPTH] = 1'b1;
    end
    send_byte(csum, (27 + n) == err_pos, pick_gap(max_gap));
    rx = !sync && err_pos >= 27 && err_pos <= 27 + n;
    exp_ack[eack_n % 256] = exp_code(rx, bad_sum); eack_n++;
    if (!rx && !bad_sum) begin exp_br[ebr_n % 256] = addr; ebr_n++; end
    exp_we += n;
  endtask

  task automatic verify();
    idle(4);
    chk(ack_n == eack_n, "R5 ack count", ack_n, eack_n);
    for (int i = ack_seen; i < ack_n && i < eack_n; i++)
      chk(ack_log[i % 256] == exp_ack[i % 256], req_of(exp_ack[i % 256]), ack_log[i % 256], exp_ack[i % 256]);
    ack_seen = ack_n;
    chk(br_n == ebr_n, "R10 branch count", br_n, ebr_n);
    for (int i = br_seen; i < br_n && i < ebr_n; i++)
      chk(br_log[i % 256] == exp_br[i % 256], "R10 branch addr", br_log[i % 256], exp_br[i % 256]);
    br_seen = br_n;
    chk(timing_err == 0, "R10 R5 strobe timing", timing_err, 0);
    chk(we_n == exp_we, "R3 write count", we_n, exp_we);
    for (int a = 0; a < DEPTH; a++)
      if (etouch[a]) chk(mem[a] === emem[a], "R3 ram data", mem[a], emem[a]);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int a = 0; a < DEPTH; a++) etouch[a] = 1'b0;
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    // R1 reset state
    chk(!ack_vld_o && !branch_req_o && !ram_we_o, "R1 reset outputs",
        {ack_vld_o, branch_req_o, ram_we_o}, 0);
    // R2 stray bytes while waiting for a command
    send_byte(8'h55, 1'b0, 0); send_byte(8'h11, 1'b0, 1);
    send_byte(8'h00, 1'b0, 0); send_byte(8'hFF, 1'b1, 2);
    idle(3);
    chk(ack_n == 0 && we_n == 0, "R2 stray bytes ignored", ack_n + we_n, 0);
    // R4 empty payload
    send_pkt(0, 32'h0000_0400, 0, -1, 0, 0, 0, 0); verify();
    // R5 clean packet with gaps (R12)
    send_pkt(5, 32'h1234_5678, 0, -1, 0, 3, 0, 2); verify();
    // R6 bad checksum
    send_pkt(8, 32'hDEAD_BEEF, 1, -1, 0, 0, 0, 0); verify();
    // R7 receive error on first payload byte, and on checksum byte with bad sum
    send_pkt(4, 32'hA5A5_0001, 0, 27, 0, 0, 0, 0); verify();
    send_pkt(6, 32'hA5A5_0002, 1, 33, 0, 1, 0, 0); verify();
    // R8 receive errors on command and header only
    send_pkt(3, 32'h0BAD_F00D, 0, 20, 0, 0, 1, 0); verify();
    // R9 synchronous mode masks receive errors
    send_pkt(7, 32'h7777_0000, 0, 29, 1, 0, 0, 0); verify();
    send_pkt(7, 32'h7777_0001, 1, 29, 1, 0, 0, 0); verify();
    sync_mode = 1'b0;
    // R3 address wrap past the RAM depth
    send_pkt(70, 32'hFFFF_FFF0, 0, -1, 0, 0, 0, 0); verify();
    // R11 back-to-back packets: next command in the acknowledge cycle
    send_pkt(2, 32'h1111_1111, 0, -1, 0, 0, 0, 0);
    send_pkt(1, 32'h2222_2222, 1, -1, 0, 0, 0, 0);
    send_pkt(0, 32'h3333_3333, 0, -1, 0, 0, 0, 0);
    send_pkt(4, 32'h4444_4444, 0, -1, 0, 0, 0, 0);
    verify();
    // R1 reset in the middle of a packet
    send_byte(8'h10, 1'b0, 0);
    for (int p = 4; p <= 26; p++) send_byte(p == 24 ? 8'd10 : 8'h00, 1'b0, 0);
    for (int k = 0; k < 3; k++) begin
      send_byte(8'h90 + 8'(k), 1'b0, 0);
      emem[k] = 8'h90 + 8'(k); etouch[k] = 1'b1;
    end
    exp_we += 3;
    idle(2);
    rst_ni = 1'b0; idle(2); rst_ni = 1'b1; idle(1);
    chk(!ack_vld_o && !branch_req_o && !ram_we_o, "R1 outputs after mid reset",
        {ack_vld_o, branch_req_o, ram_we_o}, 0);
    send_pkt(5, 32'h5555_AAAA, 0, -1, 0, 0, 0, 0); verify();
    // random mix
    for (int t = 0; t < 30; t++) begin
      int n, ep;
      bit bad, syn;
      n   = int'($urandom_range(0, 40));
      bad = ($urandom_range(0, 3) == 0);
      syn = ($urandom_range(0, 3) == 0);
      ep  = ($urandom_range(0, 3) == 0) ? int'($urandom_range(3, 27 + n)) : -1;
      send_pkt(n, $urandom, bad, ep, syn, int'($urandom_range(0, 2)), 1'b0,
               ($urandom_range(0, 1) == 0) ? 0 : 1);
      if ($urandom_range(0, 2) == 0) verify();
    end
    verify();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule